// File: doc/BRIEF.md
# MDIO Management Interface Master

This block is a hardware master for the two-wire PHY management bus. A host hands it one command at a time over a request/acknowledge interface: read or write, a Clause 22 or Clause 45 format flag, a 5-bit PHY address, a 21-bit register address and 16 bits of write data. The block serialises the complete frame on the MDC clock and the MDIO data line. It controls the output enable of the MDIO pad, samples the data that the PHY returns, and reports read data with an error flag on a one-cycle done pulse.

For a Clause 45 command the block sends an address frame first and the access frame right after it, with no host involvement between them. On reads it checks the turnaround bit that the PHY drives. When that bit is bad it flushes the bus and returns all ones with an error flag. A 32-bit per-PHY mask can disable this check. Two programmable counts, in system clocks, set the MDC half period and the MDC high time of input bits. Both counts are latched when a command is accepted.

Top module: `mdio_master`

## Requirements
- R1: While idle, `mdc_o` is low, `mdio_oe_o` is low, `mdio_o` is low and `busy_o` is low; `mdio_o` is low in every cycle where `mdio_oe_o` is low.
- R2: Every frame begins with 32 driven ones. A Clause 22 frame continues with start bits 0,1, then opcode 1,0 for a read or 0,1 for a write, then the PHY address and then `addr_i[4:0]`, each 5 bits MSB first.
- R3: A Clause 45 command sends two frames back to back, both with start bits 0,0 and `addr_i[20:16]` in the 5-bit field after the PHY address. The first is an address frame (opcode 0,0) carrying `addr_i[15:0]` as its payload. The second uses opcode 0,1 for a write or 1,1 for a read.
- R4: Write and address frames drive the turnaround as 1 then 0, then 16 payload bits MSB first. After that the master releases MDIO for one input-timed bit.
- R5: On a read frame the master releases MDIO after the register field and samples one turnaround bit. If it is 0, the master shifts in 16 bits MSB first into `rdata_o`, clocks one further input-timed bit, and reports `err_o`=0.
- R6: If the turnaround bit reads 1 and the PHY's mask bit is clear, the master clocks 32 input-timed bits. It then reports `rdata_o`=16'hFFFF and `err_o`=1.
- R7: If bit `phy` of `ta_ignore_i` is set, the turnaround value is disregarded and the read proceeds as in R5.
- R8: An output bit holds MDC low for `half_cnt_i` clocks and then high for `half_cnt_i` clocks, with MDIO constant across the whole bit. An input bit holds MDC low for `half_cnt_i` clocks and high for `rd_high_cnt_i` clocks. It is sampled at the edge that ends the high phase, after a two-flop input synchroniser. Bits follow with no gap. With a 4 ns clock, counts of 50 and 88 give a 400 ns period and a 352 ns read high time.
- R9: A command is accepted when `req_i` is high and `busy_o` is low. `busy_o` is high from the next cycle through the last bit. `done_o` pulses for one cycle right after the last bit, with `busy_o` low and `rdata_o`/`err_o` valid.
- R10: `req_i` raised while `busy_o` is high has no effect on the frame in progress and starts no later command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Command request |
| write_i | input | 1 | 1 = write, 0 = read |
| c45_i | input | 1 | 1 = Clause 45 format |
| phy_i | input | 5 | PHY address |
| addr_i | input | 21 | Device address [20:16], register [15:0] (Clause 22 uses [4:0]) |
| wdata_i | input | 16 | Write data |
| ta_ignore_i | input | 32 | Per-PHY turnaround check override |
| half_cnt_i | input | CNT_W | MDC half period in clocks |
| rd_high_cnt_i | input | CNT_W | MDC high time of input bits in clocks |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read data |
| err_o | output | 1 | Bad turnaround on read |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO pad input |

## Verification
The bench builds the expected MDC, MDIO and enable level of every clock from the frame rules and compares it against the design cycle by cycle. A register-array PHY model supplies the read data. Clause 22 and Clause 45 writes followed by reads of the same locations show that the field order and the two-frame sequence are right, and that read data comes back through the sampling path. A read from an absent PHY (turnaround pulled high) exercises the flush path, both in a Clause 22 frame and in the second frame of a Clause 45 access. The same bad turnaround with the mask bit set shows the override. A run with the 400 ns timing counts separates the low and high phase counts, and a request pulsed mid-frame shows that commands arriving while busy are dropped.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_W    = 5;
  localparam int ADDR_W   = 21;
  localparam int DATA_W   = 16;
  localparam int PRE_BITS = 32;
  localparam int FRM_BITS = PRE_BITS + 2 + 2 + PHY_W + PHY_W + 2 + DATA_W;
  localparam int HDR_BITS = PRE_BITS + 2 + 2 + PHY_W + PHY_W;
  localparam int FLUSH_BITS = 32;
  localparam int BCNT_W   = $clog2(FRM_BITS + 1);

  localparam logic [1:0] OP_C22_RD  = 2'b10;
  localparam logic [1:0] OP_C22_WR  = 2'b01;
  localparam logic [1:0] OP_C45_ADR = 2'b00;
  localparam logic [1:0] OP_C45_WR  = 2'b01;
  localparam logic [1:0] OP_C45_RD  = 2'b11;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_TX, SQ_TA, SQ_RX, SQ_TAIL, SQ_FLUSH
  } seq_state_e;

  typedef enum logic [1:0] {PH_OFF, PH_LO, PH_HI} mdc_phase_e;

  function automatic logic [FRM_BITS-1:0] mk_frame(
      input logic c45, input logic [1:0] op, input logic [PHY_W-1:0] phy,
      input logic [PHY_W-1:0] fld, input logic [DATA_W-1:0] data);
    return {{PRE_BITS{1'b1}}, 1'b0, ~c45, op, phy, fld, 2'b10, data};
  endfunction
endpackage

// File: rtl/mdio_bit_tmr.sv
module mdio_bit_tmr
  import mdio_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             is_rx_i,
  input  logic [CNT_W-1:0] half_i,
  input  logic [CNT_W-1:0] rdhi_i,
  output logic             mdc_o,
  output logic             end_o
);
  mdc_phase_e       phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rx_q;

  assign mdc_o = (phase_q == PH_HI);
  assign end_o = (phase_q == PH_HI) && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_OFF;
      cnt_q   <= '0;
      rx_q    <= 1'b0;
    end else if (start_i) begin
      phase_q <= PH_LO;
      cnt_q   <= half_i - 1'b1;
      rx_q    <= is_rx_i;
    end else begin
      case (phase_q)
        PH_LO: begin
          if (cnt_q == '0) begin
            phase_q <= PH_HI;
            cnt_q   <= (rx_q ? rdhi_i : half_i) - 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_HI: begin
          if (cnt_q == '0) phase_q <= PH_OFF;
          else cnt_q <= cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  // a new bit may only start on a bit boundary
  assert_start_boundary_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (phase_q == PH_OFF) || end_o);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              write_i,
  input  logic              c45_i,
  input  logic [PHY_W-1:0]  phy_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [31:0]       ta_ignore_i,
  input  logic              bit_end_i,
  input  logic              rx_bit_i,
  output logic              accept_o,
  output logic              bit_start_o,
  output logic              bit_rx_o,
  output logic              tx_o,
  output logic              oe_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o
);
  seq_state_e          state_q, nxt;
  logic [FRM_BITS-1:0] sh_q;
  logic [BCNT_W-1:0]   cnt_q;
  logic                wr_q, adr_ph_q, done_q, err_q;
  logic [PHY_W-1:0]    phy_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q, rdata_q;
  logic                rd_frame, ta_bad, last;

  assign accept_o = (state_q == SQ_IDLE) && req_i;
  assign rd_frame = !wr_q && !adr_ph_q;
  assign ta_bad   = rx_bit_i && !ta_ignore_i[phy_q];
  assign last     = (cnt_q == BCNT_W'(1));

  always_comb begin
    nxt = state_q;
    case (state_q)
      SQ_IDLE:  if (req_i) nxt = SQ_TX;
      SQ_TX:    if (bit_end_i && last) nxt = rd_frame ? SQ_TA : SQ_TAIL;
      SQ_TA:    if (bit_end_i) nxt = ta_bad ? SQ_FLUSH : SQ_RX;
      SQ_RX:    if (bit_end_i && last) nxt = SQ_TAIL;
      SQ_TAIL:  if (bit_end_i) nxt = adr_ph_q ? SQ_TX : SQ_IDLE;
      SQ_FLUSH: if (bit_end_i && last) nxt = SQ_IDLE;
      default:  nxt = SQ_IDLE;
    endcase
  end

  assign bit_start_o = accept_o || (bit_end_i && nxt != SQ_IDLE);
  assign bit_rx_o    = (nxt != SQ_TX);
  assign oe_o        = (state_q == SQ_TX);
  assign tx_o        = sh_q[FRM_BITS-1];
  assign busy_o      = (state_q != SQ_IDLE);
  assign done_o      = done_q;
  assign rdata_o     = rdata_q;
  assign err_o       = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SQ_IDLE;
      sh_q     <= '0;
      cnt_q    <= '0;
      wr_q     <= 1'b0;
      adr_ph_q <= 1'b0;
      phy_q    <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q <= nxt;
      done_q  <= (state_q != SQ_IDLE) && (nxt == SQ_IDLE);
      case (state_q)
        SQ_IDLE: if (req_i) begin
          wr_q     <= write_i;
          adr_ph_q <= c45_i;
          phy_q    <= phy_i;
          addr_q   <= addr_i;
          wdata_q  <= wdata_i;
          rdata_q  <= '0;
          err_q    <= 1'b0;
          sh_q     <= c45_i ? mk_frame(1'b1, OP_C45_ADR, phy_i, addr_i[20:16], addr_i[15:0])
                            : mk_frame(1'b0, write_i ? OP_C22_WR : OP_C22_RD, phy_i,
                                       addr_i[4:0], wdata_i);
          cnt_q    <= (c45_i || write_i) ? BCNT_W'(FRM_BITS) : BCNT_W'(HDR_BITS);
        end
        SQ_TX: if (bit_end_i) begin
          sh_q  <= sh_q << 1;
          cnt_q <= cnt_q - 1'b1;
        end
        SQ_TA: if (bit_end_i) begin
          cnt_q <= ta_bad ? BCNT_W'(FLUSH_BITS) : BCNT_W'(DATA_W);
        end
        SQ_RX: if (bit_end_i) begin
          rdata_q <= {rdata_q[DATA_W-2:0], rx_bit_i};
          cnt_q   <= cnt_q - 1'b1;
        end
        SQ_TAIL: if (bit_end_i && adr_ph_q) begin
          adr_ph_q <= 1'b0;
          sh_q     <= mk_frame(1'b1, wr_q ? OP_C45_WR : OP_C45_RD, phy_q,
                               addr_q[20:16], wdata_q);
          cnt_q    <= wr_q ? BCNT_W'(FRM_BITS) : BCNT_W'(HDR_BITS);
        end
        SQ_FLUSH: if (bit_end_i) begin
          cnt_q <= cnt_q - 1'b1;
          if (last) begin
            rdata_q <= '1;
            err_q   <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // command fields are frozen while a command runs
  assert_ignore_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && req_i) |=> $stable(phy_q) && $stable(wr_q) && $stable(addr_q));
  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              write_i,
  input  logic              c45_i,
  input  logic [PHY_W-1:0]  phy_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [31:0]       ta_ignore_i,
  input  logic [CNT_W-1:0]  half_cnt_i,
  input  logic [CNT_W-1:0]  rd_high_cnt_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  logic [CNT_W-1:0] half_q, rdhi_q, half_use, rdhi_use;
  logic [1:0]       sync_q;
  logic             accept, bit_start, bit_rx, bit_end, tx_bit, oe;

  function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  assign half_use = accept ? at_least_one(half_cnt_i)    : half_q;
  assign rdhi_use = accept ? at_least_one(rd_high_cnt_i) : rdhi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= CNT_W'(1);
      rdhi_q <= CNT_W'(1);
      sync_q <= 2'b11;
    end else begin
      sync_q <= {sync_q[0], mdio_i};
      if (accept) begin
        half_q <= half_use;
        rdhi_q <= rdhi_use;
      end
    end
  end

  mdio_frame_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .write_i     (write_i),
    .c45_i       (c45_i),
    .phy_i       (phy_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .ta_ignore_i (ta_ignore_i),
    .bit_end_i   (bit_end),
    .rx_bit_i    (sync_q[1]),
    .accept_o    (accept),
    .bit_start_o (bit_start),
    .bit_rx_o    (bit_rx),
    .tx_o        (tx_bit),
    .oe_o        (oe),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .rdata_o     (rdata_o),
    .err_o       (err_o)
  );

  mdio_bit_tmr #(.CNT_W(CNT_W)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (bit_start),
    .is_rx_i (bit_rx),
    .half_i  (half_use),
    .rdhi_i  (rdhi_use),
    .mdc_o   (mdc_o),
    .end_o   (bit_end)
  );

  assign mdio_oe_o = oe;
  assign mdio_o    = tx_bit & oe;

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mdc_o && !mdio_oe_o);
  // data settles during the low phase, before MDC rises
  assert_setup_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_o) |-> $stable(mdio_o) && $stable(mdio_oe_o));
  assert_flush_value_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (rdata_o == 16'hFFFF));
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic        req = 1'b0, wr = 1'b0, c45 = 1'b0, mdi = 1'b1;
  logic [4:0]  phy = '0;
  logic [20:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [31:0] mask = '0;
  logic [CW-1:0] hc = CW'(3), rc = CW'(5);
  logic        busy, done, err, mdc, mdo, oe;
  logic [15:0] rdata;

  mdio_master #(.CNT_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .write_i(wr), .c45_i(c45),
    .phy_i(phy), .addr_i(addr), .wdata_i(wdata), .ta_ignore_i(mask),
    .half_cnt_i(hc), .rd_high_cnt_i(rc), .busy_o(busy), .done_o(done),
    .rdata_o(rdata), .err_o(err), .mdc_o(mdc), .mdio_o(mdo),
    .mdio_oe_o(oe), .mdio_i(mdi)
  );

  typedef struct packed {logic mdc; logic oe; logic mdo; logic drv;} cyc_t;
  cyc_t q[$];
  int H = 3, R = 5;
  int total = 0, bad = 0;
  bit finished = 0;
  logic [15:0] regs [int];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic void tx(input logic b);
    for (int i = 0; i < 2 * H; i++) q.push_back({logic'(i >= H), 1'b1, b, b});
  endfunction

  function automatic void rx(input logic v);
    for (int i = 0; i < H + R; i++) q.push_back({logic'(i >= H), 1'b0, 1'b0, v});
  endfunction

  function automatic void frame(input logic f45, input logic [1:0] op,
                                input logic [4:0] p, input logic [4:0] fld);
    for (int i = 0; i < 32; i++) tx(1'b1);
    tx(1'b0); tx(!f45); tx(op[1]); tx(op[0]);
    for (int i = 4; i >= 0; i--) tx(p[i]);
    for (int i = 4; i >= 0; i--) tx(fld[i]);
  endfunction

  function automatic void wr_tail(input logic [15:0] d);
    tx(1'b1); tx(1'b0);
    for (int i = 15; i >= 0; i--) tx(d[i]);
    rx(1'b1);
  endfunction

  function automatic void rd_tail(input logic ta, input bit good, input logic [15:0] d);
    rx(ta);
    if (good) begin
      for (int i = 15; i >= 0; i--) rx(d[i]);
      rx(1'b1);
    end else begin
      for (int i = 0; i < 32; i++) rx(1'b1);
    end
  endfunction

  task automatic run(input logic w, input logic f45, input logic [4:0] p,
                     input logic [20:0] a, input logic [15:0] wd, input bit inject,
                     input logic [15:0] exp_rd, input logic exp_err, input bit rd_chk,
                     input string tag);
    int miss = 0;
    logic [3:0] fa = '0, fe = '0;
    @(negedge clk);
    req = 1'b1; wr = w; c45 = f45; phy = p; addr = a; wdata = wd;
    @(negedge clk);
    req = 1'b0;
    foreach (q[i]) begin
      if (i > 0) @(negedge clk);
      mdi = q[i].drv;
      if (inject && i == 20) begin req = 1'b1; wr = !w; phy = p + 5'd1; end
      if (inject && i == 21) req = 1'b0;
      if ({mdc, oe, mdo, busy} !== {q[i].mdc, q[i].oe, q[i].mdo, 1'b1}) begin
        if (miss == 0) begin fa = {mdc, oe, mdo, busy}; fe = {q[i].mdc, q[i].oe, q[i].mdo, 1'b1}; end
        miss++;
      end
    end
    chk(miss == 0, {tag, " waveform mdc/oe/mdo/busy"}, 32'(fa), 32'(fe));
    @(negedge clk);
    mdi = 1'b1;
    chk(done === 1'b1 && busy === 1'b0 && mdc === 1'b0 && oe === 1'b0,
        {tag, " R9 done pulse"}, {28'd0, done, busy, mdc, oe}, 32'h8);
    chk(err === exp_err, {tag, " err flag"}, 32'(err), 32'(exp_err));
    if (rd_chk) chk(rdata === exp_rd, {tag, " read data"}, 32'(rdata), 32'(exp_rd));
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0 && mdc === 1'b0,
        {tag, " R9/R10 idle after done"}, {29'd0, done, busy, mdc}, 32'h0);
    q.delete();
  endtask

  task automatic do_write(input logic f45, input logic [4:0] p, input logic [20:0] a,
                          input logic [15:0] d, input bit inject, input string tag);
    if (f45) begin
      frame(1'b1, 2'b00, p, a[20:16]); wr_tail(a[15:0]);
      frame(1'b1, 2'b01, p, a[20:16]); wr_tail(d);
    end else begin
      frame(1'b0, 2'b01, p, a[4:0]); wr_tail(d);
    end
    regs[int'({f45, p, f45 ? a : {16'd0, a[4:0]}})] = d;
    run(1'b1, f45, p, a, d, inject, 16'h0, 1'b0, 1'b0, tag);
  endtask

  task automatic do_read(input logic f45, input logic [4:0] p, input logic [20:0] a,
                         input logic ta, input string tag);
    int k = int'({f45, p, f45 ? a : {16'd0, a[4:0]}});
    logic [15:0] d = regs.exists(k) ? regs[k] : 16'h0;
    bit good = (ta == 1'b0) || mask[p];
    if (f45) begin
      frame(1'b1, 2'b00, p, a[20:16]); wr_tail(a[15:0]);
      frame(1'b1, 2'b11, p, a[20:16]);
    end else begin
      frame(1'b0, 2'b10, p, a[4:0]);
    end
    rd_tail(ta, good, d);
    run(1'b0, f45, p, a, 16'h0, 1'b0, good ? d : 16'hFFFF, !good, 1'b1, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mdc === 1'b0 && oe === 1'b0 && mdo === 1'b0 && busy === 1'b0 && done === 1'b0,
        "R1 reset state", {27'd0, mdc, oe, mdo, busy, done}, 32'h0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(mdc === 1'b0 && oe === 1'b0 && busy === 1'b0, "R1 idle after reset",
        {29'd0, mdc, oe, busy}, 32'h0);

    do_write(1'b0, 5'd5, 21'h1A, 16'hA5C3, 1'b0, "R2/R4/R8 c22 write");
    do_read(1'b0, 5'd5, 21'h1A, 1'b0, "R2/R5 c22 read");
    do_write(1'b1, 5'd3, {5'd7, 16'h8001}, 16'h1234, 1'b1, "R3/R4/R10 c45 write busy req");
    do_read(1'b1, 5'd3, {5'd7, 16'h8001}, 1'b0, "R3/R5 c45 read");
    do_read(1'b0, 5'd9, 21'h02, 1'b1, "R6 c22 bad turnaround");
    do_read(1'b1, 5'd4, {5'd1, 16'h0010}, 1'b1, "R6/R3 c45 bad turnaround");
    do_write(1'b0, 5'd9, 21'h02, 16'h0F0F, 1'b0, "R2 c22 write phy9");
    mask = 32'h0000_0200;
    do_read(1'b0, 5'd9, 21'h02, 1'b1, "R7 masked turnaround");
    mask = 32'h0;
    H = 50; R = 88; hc = CW'(50); rc = CW'(88);
    do_read(1'b0, 5'd5, 21'h1A, 1'b0, "R8 400ns timing read");

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(1'b0, "watchdog expired", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule